// File: doc/BRIEF.md
# Cache Input Queue Dispatcher

This block sits at the front of a second-level cache. It takes entries from four incoming queues and one staged cache-to-cache copy and sends each one to the pipeline that handles it. The four queues are coherence, noncoherent control, reply and request. Each queue shows its head entry with a valid flag and is advanced by a one-cycle pop pulse. Every pipeline is a valid/ready sink. The copy goes to the single data pipeline. Coherence, reply and request entries each go to their own tag pipeline. Coherence traffic has a pipe of its own so that snoops can never sit behind stalled demand traffic. Noncoherent control entries are passed to a control handshake.

Back-pressure follows the valid/ready rules. An offer toward a pipeline depends only on the queue head and the arbitration budget, never on that pipeline's ready. An entry transfers in a cycle where valid and ready are both high. A queue is popped in exactly that cycle. A refused head stays where it is and is offered again in later cycles. Each queue moves at most one entry per cycle. A queue therefore drains over successive cycles for as long as its pipe keeps accepting. The tag array has a limited number of ports per cycle, so the tag offers are granted in a fixed order.

The block keeps a count of the entries that are inside the pipelines. Each transfer adds one and each retire pulse removes one, and both can happen in the same cycle. It also raises a flag when the previous cycle left no input holding an entry that it could not deliver.

Top module: `cache_inq_dispatch`

## Requirements
- R1: A `copy_set` pulse while no copy is staged captures `copy_entry`. From the next cycle the staged copy is offered on the data pipe, unchanged, until a cycle with `dpipe_ready` high, and is then dropped. A `copy_set` that arrives while a copy is staged is ignored.
- R2: Coherence heads go only to the coherence tag pipe. Coherence, reply and request heads each go to their own pipe.
- R3: At most TAG_PORTS tag offers (default 2) are made per cycle, granted in the order coherence, reply, request. A valid head is offered only if fewer than TAG_PORTS heads ahead of it in that order are valid.
- R4: A queue pops in exactly the cycles where its offer is accepted, one entry per cycle. A refused head is not popped and stays offered.
- R5: Entries sent to a tag pipe have their progress field cleared. The progress field is the top PROG_W bits of the entry, default [15:12]. All other bits pass through unchanged.
- R6: A noncoherent head whose `nc_head_is_ctrl` is 1 is offered on the control handshake unchanged. It is popped only in a cycle with `ctl_ready` high.
- R7: A noncoherent head whose `nc_head_is_ctrl` is 0 is never offered and never popped. `nc_kind_err` is high in the cycle after each cycle in which such a head is present.
- R8: `occupancy` rises by the number of transfers on the four pipelines and falls by the number of set `retire` bits, both in the same update. Control handshakes do not count.
- R9: `inputs_clear` is registered. It is 1 after a cycle in which no valid head, staged copy or noncoherent head was left unaccepted, and 0 otherwise.
- R10: After reset, `occupancy` is 0, no copy is staged, `inputs_clear` is 1 and `nc_kind_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| copy_set | input | 1 | Stage a cache-to-cache copy |
| copy_entry | input | ENTRY_W | Copy payload |
| dpipe_valid | output | 1 | Data pipe offer |
| dpipe_entry | output | ENTRY_W | Data pipe payload |
| dpipe_ready | input | 1 | Data pipe accepts |
| coh_head_valid | input | 1 | Coherence queue non-empty |
| coh_head | input | ENTRY_W | Coherence head entry |
| coh_pop | output | 1 | Coherence queue advance |
| cpipe_valid | output | 1 | Coherence tag pipe offer |
| cpipe_entry | output | ENTRY_W | Coherence tag pipe payload |
| cpipe_ready | input | 1 | Coherence tag pipe accepts |
| nc_head_valid | input | 1 | Noncoherent queue non-empty |
| nc_head | input | ENTRY_W | Noncoherent head entry |
| nc_head_is_ctrl | input | 1 | Head is a control request |
| nc_pop | output | 1 | Noncoherent queue advance |
| ctl_valid | output | 1 | Control handshake offer |
| ctl_entry | output | ENTRY_W | Control payload |
| ctl_ready | input | 1 | Control side accepts |
| nc_kind_err | output | 1 | Unsupported noncoherent entry seen |
| rep_head_valid | input | 1 | Reply queue non-empty |
| rep_head | input | ENTRY_W | Reply head entry |
| rep_pop | output | 1 | Reply queue advance |
| rpipe_valid | output | 1 | Reply tag pipe offer |
| rpipe_entry | output | ENTRY_W | Reply tag pipe payload |
| rpipe_ready | input | 1 | Reply tag pipe accepts |
| req_head_valid | input | 1 | Request queue non-empty |
| req_head | input | ENTRY_W | Request head entry |
| req_pop | output | 1 | Request queue advance |
| qpipe_valid | output | 1 | Request tag pipe offer |
| qpipe_entry | output | ENTRY_W | Request tag pipe payload |
| qpipe_ready | input | 1 | Request tag pipe accepts |
| retire | input | 4 | Completion pulses, one per pipeline |
| occupancy | output | OCC_W | Entries in pipelines |
| inputs_clear | output | 1 | No input left stranded last cycle |

## Verification
The assertions check several properties on every cycle. Pops happen only on accepted transfers. The number of tag offers never exceeds the port budget. A request head is held back only when the budget has been used up. The progress field is clear on tag offers. Kind-error heads are neither offered nor popped. A refused copy stays unchanged on the data pipe. The occupancy update matches the transfers and retires. A stranded head clears `inputs_clear`. The bench's behavioural model covers what needs a history of stimulus: whole queues draining over several cycles, the ordering of offers across the three tag classes under changing ready patterns, a `copy_set` ignored while a copy is staged, and occupancy tracking over long runs of mixed dispatch and retire.

// File: rtl/cid_pkg.sv
package cid_pkg;
  localparam int NUM_TAG_CLASSES = 3;
  localparam int NUM_PIPES       = 4;
  // grant order of the tag classes; lower index wins
  typedef enum logic [1:0] {
    CLS_COH = 2'd0,
    CLS_REP = 2'd1,
    CLS_REQ = 2'd2
  } tag_cls_e;
endpackage

// File: rtl/cid_copy_slot.sv
module cid_copy_slot #(
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ENTRY_W-1:0] load_entry,
  output logic               out_valid,
  output logic [ENTRY_W-1:0] out_entry,
  input  logic               out_ready,
  output logic               taken,
  output logic               stranded
);
  logic               held_q;
  logic [ENTRY_W-1:0] ent_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      ent_q  <= '0;
    end else if (!held_q) begin
      if (load) begin
        held_q <= 1'b1;
        ent_q  <= load_entry;
      end
    end else if (out_ready) begin
      held_q <= 1'b0;
    end
  end

  always_comb begin
    out_valid = held_q;
    out_entry = ent_q;
    taken     = held_q && out_ready;
    stranded  = held_q && !out_ready;
  end
endmodule

// File: rtl/cid_tag_offer.sv
module cid_tag_offer #(
  parameter int N     = 3,
  parameter int PORTS = 2
) (
  input  logic [N-1:0] head_valid,
  input  logic [N-1:0] pipe_ready,
  output logic [N-1:0] offer,
  output logic [N-1:0] take,
  output logic         stranded
);
  localparam int CW = $clog2(N + 1) + 1;

  logic [CW-1:0] used [N+1];
  assign used[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_cls
    assign offer[i]  = head_valid[i] && (used[i] < CW'(PORTS));
    assign used[i+1] = used[i] + CW'(offer[i]);
    assign take[i]   = offer[i] && pipe_ready[i];
  end

  assign stranded = |(head_valid & ~take);
endmodule

// File: rtl/cid_nc_handoff.sv
module cid_nc_handoff #(
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               head_valid,
  input  logic [ENTRY_W-1:0] head,
  input  logic               head_is_ctrl,
  output logic               pop,
  output logic               ctl_valid,
  output logic [ENTRY_W-1:0] ctl_entry,
  input  logic               ctl_ready,
  output logic               stranded,
  output logic               kind_err
);
  logic err_q;

  always_comb begin
    ctl_valid = head_valid && head_is_ctrl;
    ctl_entry = head;
    pop       = ctl_valid && ctl_ready;
    stranded  = head_valid && !pop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= head_valid && !head_is_ctrl;
  end

  assign kind_err = err_q;
endmodule

// File: rtl/cid_occ_ctr.sv
module cid_occ_ctr #(
  parameter int W    = 8,
  parameter int NINC = 4,
  parameter int NDEC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NINC-1:0] inc,
  input  logic [NDEC-1:0] dec,
  output logic [W-1:0]    count
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] n_inc, n_dec;

  always_comb begin
    n_inc = W'($countones(inc));
    n_dec = W'($countones(dec));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + n_inc - n_dec;
  end

  assign count = cnt_q;
endmodule

// File: rtl/cache_inq_dispatch.sv
module cache_inq_dispatch
  import cid_pkg::*;
#(
  parameter int ENTRY_W   = 16,
  parameter int PROG_W    = 4,
  parameter int TAG_PORTS = 2,
  parameter int OCC_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               copy_set,
  input  logic [ENTRY_W-1:0] copy_entry,
  output logic               dpipe_valid,
  output logic [ENTRY_W-1:0] dpipe_entry,
  input  logic               dpipe_ready,
  input  logic               coh_head_valid,
  input  logic [ENTRY_W-1:0] coh_head,
  output logic               coh_pop,
  output logic               cpipe_valid,
  output logic [ENTRY_W-1:0] cpipe_entry,
  input  logic               cpipe_ready,
  input  logic               nc_head_valid,
  input  logic [ENTRY_W-1:0] nc_head,
  input  logic               nc_head_is_ctrl,
  output logic               nc_pop,
  output logic               ctl_valid,
  output logic [ENTRY_W-1:0] ctl_entry,
  input  logic               ctl_ready,
  output logic               nc_kind_err,
  input  logic               rep_head_valid,
  input  logic [ENTRY_W-1:0] rep_head,
  output logic               rep_pop,
  output logic               rpipe_valid,
  output logic [ENTRY_W-1:0] rpipe_entry,
  input  logic               rpipe_ready,
  input  logic               req_head_valid,
  input  logic [ENTRY_W-1:0] req_head,
  output logic               req_pop,
  output logic               qpipe_valid,
  output logic [ENTRY_W-1:0] qpipe_entry,
  input  logic               qpipe_ready,
  input  logic [3:0]         retire,
  output logic [OCC_W-1:0]   occupancy,
  output logic               inputs_clear
);
  localparam int NT = NUM_TAG_CLASSES;
  localparam logic [ENTRY_W-1:0] KEEP_MASK =
    {{PROG_W{1'b0}}, {(ENTRY_W-PROG_W){1'b1}}};

  // copy slot -> data pipe
  logic copy_taken, copy_stranded;

  cid_copy_slot #(.ENTRY_W(ENTRY_W)) u_copy (
    .clk(clk), .rst_n(rst_n),
    .load(copy_set), .load_entry(copy_entry),
    .out_valid(dpipe_valid), .out_entry(dpipe_entry), .out_ready(dpipe_ready),
    .taken(copy_taken), .stranded(copy_stranded)
  );

  // tag classes, indexed by tag_cls_e
  logic [NT-1:0]      t_head_v, t_ready, t_offer, t_take;
  logic [ENTRY_W-1:0] t_head [NT];
  logic [ENTRY_W-1:0] t_out  [NT];
  logic               tag_stranded;

  always_comb begin
    t_head_v[CLS_COH] = coh_head_valid;
    t_head_v[CLS_REP] = rep_head_valid;
    t_head_v[CLS_REQ] = req_head_valid;
    t_ready[CLS_COH]  = cpipe_ready;
    t_ready[CLS_REP]  = rpipe_ready;
    t_ready[CLS_REQ]  = qpipe_ready;
    t_head[CLS_COH]   = coh_head;
    t_head[CLS_REP]   = rep_head;
    t_head[CLS_REQ]   = req_head;
  end

  cid_tag_offer #(.N(NT), .PORTS(TAG_PORTS)) u_offer (
    .head_valid(t_head_v), .pipe_ready(t_ready),
    .offer(t_offer), .take(t_take), .stranded(tag_stranded)
  );

  for (genvar c = 0; c < NT; c++) begin : g_prog
    assign t_out[c] = t_head[c] & KEEP_MASK;
  end

  always_comb begin
    cpipe_valid = t_offer[CLS_COH];
    rpipe_valid = t_offer[CLS_REP];
    qpipe_valid = t_offer[CLS_REQ];
    cpipe_entry = t_out[CLS_COH];
    rpipe_entry = t_out[CLS_REP];
    qpipe_entry = t_out[CLS_REQ];
    coh_pop     = t_take[CLS_COH];
    rep_pop     = t_take[CLS_REP];
    req_pop     = t_take[CLS_REQ];
  end

  // noncoherent control handoff
  logic nc_stranded;

  cid_nc_handoff #(.ENTRY_W(ENTRY_W)) u_nc (
    .clk(clk), .rst_n(rst_n),
    .head_valid(nc_head_valid), .head(nc_head), .head_is_ctrl(nc_head_is_ctrl),
    .pop(nc_pop), .ctl_valid(ctl_valid), .ctl_entry(ctl_entry),
    .ctl_ready(ctl_ready), .stranded(nc_stranded), .kind_err(nc_kind_err)
  );

  // pipeline occupancy
  cid_occ_ctr #(.W(OCC_W), .NINC(NUM_PIPES), .NDEC(4)) u_occ (
    .clk(clk), .rst_n(rst_n),
    .inc({copy_taken, t_take}), .dec(retire), .count(occupancy)
  );

  // input-clear flag
  logic clear_q;
  always_ff @(posedge clk) begin
    if (!rst_n) clear_q <= 1'b1;
    else        clear_q <= !(copy_stranded || tag_stranded || nc_stranded);
  end
  assign inputs_clear = clear_q;
endmodule

// File: rtl/cid_checker.sv
module cid_checker #(
  parameter int ENTRY_W   = 16,
  parameter int PROG_W    = 4,
  parameter int TAG_PORTS = 2,
  parameter int OCC_W     = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dpipe_valid,
  input logic [ENTRY_W-1:0] dpipe_entry,
  input logic               dpipe_ready,
  input logic               coh_head_valid,
  input logic               coh_pop,
  input logic               cpipe_valid,
  input logic [ENTRY_W-1:0] cpipe_entry,
  input logic               cpipe_ready,
  input logic               nc_head_valid,
  input logic               nc_head_is_ctrl,
  input logic               nc_pop,
  input logic               ctl_valid,
  input logic               rep_pop,
  input logic               rpipe_valid,
  input logic               rpipe_ready,
  input logic               req_head_valid,
  input logic               req_pop,
  input logic               qpipe_valid,
  input logic               qpipe_ready,
  input logic [3:0]         retire,
  input logic [OCC_W-1:0]   occupancy,
  input logic               inputs_clear
);
  logic [OCC_W-1:0] acc_n, ret_n;
  always_comb begin
    acc_n = OCC_W'($countones({dpipe_valid && dpipe_ready, coh_pop, rep_pop, req_pop}));
    ret_n = OCC_W'($countones(retire));
  end

  assert_copy_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dpipe_valid && !dpipe_ready |=> dpipe_valid && $stable(dpipe_entry));

  assert_pop_on_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (coh_pop |-> cpipe_valid && cpipe_ready) and
    (rep_pop |-> rpipe_valid && rpipe_ready) and
    (req_pop |-> qpipe_valid && qpipe_ready));

  assert_tag_budget_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cpipe_valid, rpipe_valid, qpipe_valid}) <= TAG_PORTS);

  assert_req_yield_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_head_valid && !qpipe_valid |->
      $countones({cpipe_valid, rpipe_valid}) == TAG_PORTS);

  assert_coh_own_pipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpipe_valid |-> coh_head_valid);

  assert_prog_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpipe_valid |-> cpipe_entry[ENTRY_W-1 -: PROG_W] == '0);

  assert_bad_kind_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nc_head_valid && !nc_head_is_ctrl |-> !nc_pop && !ctl_valid);

  assert_occ_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> occupancy == $past(occupancy) + $past(acc_n) - $past(ret_n));

  assert_stranded_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    coh_head_valid && !coh_pop |=> !inputs_clear);
endmodule

bind cache_inq_dispatch cid_checker #(
  .ENTRY_W(ENTRY_W), .PROG_W(PROG_W), .TAG_PORTS(TAG_PORTS), .OCC_W(OCC_W)
) u_chk (.*);

// File: tb/sim_cache_inq_dispatch.sv
module sim_cache_inq_dispatch;
  localparam int EW = 16, PW = 4, TP = 2, OW = 8;
  localparam logic [EW-1:0] KEEP = 16'h0FFF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic copy_set = 0; logic [EW-1:0] copy_entry = '0;
  logic dpipe_valid, dpipe_ready = 0; logic [EW-1:0] dpipe_entry;
  logic coh_head_valid = 0, coh_pop, cpipe_valid, cpipe_ready = 0;
  logic [EW-1:0] coh_head = '0, cpipe_entry;
  logic nc_head_valid = 0, nc_head_is_ctrl = 0, nc_pop, ctl_valid, ctl_ready = 0, nc_kind_err;
  logic [EW-1:0] nc_head = '0, ctl_entry;
  logic rep_head_valid = 0, rep_pop, rpipe_valid, rpipe_ready = 0;
  logic [EW-1:0] rep_head = '0, rpipe_entry;
  logic req_head_valid = 0, req_pop, qpipe_valid, qpipe_ready = 0;
  logic [EW-1:0] req_head = '0, qpipe_entry;
  logic [3:0] retire = '0;
  logic [OW-1:0] occupancy;
  logic inputs_clear;

  cache_inq_dispatch #(.ENTRY_W(EW), .PROG_W(PW), .TAG_PORTS(TP), .OCC_W(OW)) u0 (.*);

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  logic [EW-1:0] cq[$], rq[$], qq[$], nq[$];
  bit nk[$];
  bit pend_m = 0; logic [EW-1:0] pent_m = '0;
  int occ_m = 0; bit clr_m = 1, err_m = 0;

  task automatic drive_inputs(int pr_rdy, int pr_push);
    if ($urandom_range(99) < pr_push) cq.push_back(EW'($urandom));
    if ($urandom_range(99) < pr_push) rq.push_back(EW'($urandom));
    if ($urandom_range(99) < pr_push) qq.push_back(EW'($urandom));
    if ($urandom_range(99) < pr_push / 2) begin
      nq.push_back(EW'($urandom)); nk.push_back($urandom_range(9) != 0);
    end
    coh_head_valid = cq.size() > 0; coh_head = cq.size() > 0 ? cq[0] : '0;
    rep_head_valid = rq.size() > 0; rep_head = rq.size() > 0 ? rq[0] : '0;
    req_head_valid = qq.size() > 0; req_head = qq.size() > 0 ? qq[0] : '0;
    nc_head_valid  = nq.size() > 0; nc_head  = nq.size() > 0 ? nq[0] : '0;
    nc_head_is_ctrl = nk.size() > 0 ? nk[0] : 1'b0;
    dpipe_ready = $urandom_range(99) < pr_rdy;
    cpipe_ready = $urandom_range(99) < pr_rdy;
    rpipe_ready = $urandom_range(99) < pr_rdy;
    qpipe_ready = $urandom_range(99) < pr_rdy;
    ctl_ready   = $urandom_range(99) < pr_rdy;
    copy_set    = $urandom_range(3) == 0;
    copy_entry  = EW'($urandom);
    if (occ_m > 100)     retire = 4'hF;
    else if (occ_m >= 4) retire = 4'($urandom);
    else                 retire = '0;
  endtask

  task automatic compare_and_step();
    int used = 0, acc = 0;
    bit co, ro, qo, nv, left;
    co = cq.size() > 0 && used < TP; used += int'(co);
    ro = rq.size() > 0 && used < TP; used += int'(ro);
    qo = qq.size() > 0 && used < TP;
    nv = nq.size() > 0;
    // registered state
    chk("R1 dpipe_valid", 32'(dpipe_valid), 32'(pend_m));
    if (pend_m) chk("R1 dpipe_entry", 32'(dpipe_entry), 32'(pent_m));
    chk("R8 occupancy", 32'(occupancy), 32'(occ_m[OW-1:0]));
    chk("R9 inputs_clear", 32'(inputs_clear), 32'(clr_m));
    chk("R7 nc_kind_err", 32'(nc_kind_err), 32'(err_m));
    // offers and pops
    chk("R2 cpipe_valid", 32'(cpipe_valid), 32'(co));
    chk("R3 rpipe_valid", 32'(rpipe_valid), 32'(ro));
    chk("R3 qpipe_valid", 32'(qpipe_valid), 32'(qo));
    chk("R4 coh_pop", 32'(coh_pop), 32'(co && cpipe_ready));
    chk("R4 rep_pop", 32'(rep_pop), 32'(ro && rpipe_ready));
    chk("R4 req_pop", 32'(req_pop), 32'(qo && qpipe_ready));
    if (co) chk("R5 cpipe_entry", 32'(cpipe_entry), 32'(cq[0] & KEEP));
    if (ro) chk("R5 rpipe_entry", 32'(rpipe_entry), 32'(rq[0] & KEEP));
    if (qo) chk("R5 qpipe_entry", 32'(qpipe_entry), 32'(qq[0] & KEEP));
    chk("R6 ctl_valid", 32'(ctl_valid), 32'(nv && nk[0]));
    chk("R6 nc_pop", 32'(nc_pop), 32'(nv && nk[0] && ctl_ready));
    if (nv && nk[0]) chk("R6 ctl_entry", 32'(ctl_entry), 32'(nq[0]));
    // next state
    left = (pend_m && !dpipe_ready)
        || (cq.size() > 0 && !(co && cpipe_ready))
        || (rq.size() > 0 && !(ro && rpipe_ready))
        || (qq.size() > 0 && !(qo && qpipe_ready))
        || (nv && !(nk[0] && ctl_ready));
    acc = int'(pend_m && dpipe_ready) + int'(co && cpipe_ready)
        + int'(ro && rpipe_ready) + int'(qo && qpipe_ready);
    occ_m = (occ_m + acc - $countones(retire)) % (1 << OW);
    clr_m = !left;
    err_m = nv && !nk[0];
    if (!pend_m) begin
      if (copy_set) begin pend_m = 1; pent_m = copy_entry; end
    end else if (dpipe_ready) pend_m = 0;
    if (co && cpipe_ready) void'(cq.pop_front());
    if (ro && rpipe_ready) void'(rq.pop_front());
    if (qo && qpipe_ready) void'(qq.pop_front());
    if (nv && nk[0] && ctl_ready) begin void'(nq.pop_front()); void'(nk.pop_front()); end
    else if (nv && !nk[0] && $urandom_range(2) == 0) begin
      void'(nq.pop_front()); void'(nk.pop_front());  // bench-side cleanup of a bad entry
    end
  endtask

  task automatic run_phase(int cycles, int pr_rdy, int pr_push);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      drive_inputs(pr_rdy, pr_push);
      @(negedge clk);
      compare_and_step();
    end
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 occupancy", 32'(occupancy), 0);
    chk("R10 inputs_clear", 32'(inputs_clear), 1);
    chk("R10 nc_kind_err", 32'(nc_kind_err), 0);
    chk("R10 dpipe_valid", 32'(dpipe_valid), 0);
    rst_n = 1'b1;
    run_phase(400, 100, 60);  // all pipes ready: budget limits the request class
    run_phase(400, 30, 70);   // heavy back-pressure: drains stall and resume
    run_phase(400, 70, 40);   // mixed
    run_phase(200, 90, 0);    // no refill: queues drain to empty
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule